// File: doc/BRIEF.md
# Calendar Clock Core with Deferred Register Commit

This block keeps wall-clock time (seconds, minutes, hours) and a calendar date (day of month, month, year offset) and advances them by one second on each cycle where the once-per-second tick input is high. Software reaches it through a small 32-bit register bus with three word registers: a status word, a date word and a time word.

Writes to the time or date word do not reach the running counters at once. The written value is held in a staging register and a busy flag for that word rises. After a fixed number of bus-clock cycles the staged value is committed into the counters and the flag drops. This models the hand-over of a new setting into a slow oscillator domain. Until that commit, reads return the counter that is still running. Software writes the leap-year flag as part of the date, and the core uses that flag to decide how long February is. A year rollover clears the flag. Software must then write it again for the next leap year.

Top module: `cal_clock_core`

## Requirements
- R1: After reset the time word reads 0x00000000, the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag 0) and the status word reads 0x00000000.
- R2: Byte address 0x00 selects the status word, 0x04 the date word and 0x08 the time word. Any other address reads zero. A read issued in one cycle shows on `bus_rdata` after the next rising edge. In the status word only bits 8 and 7 can be nonzero.
- R3: The time word holds seconds in bits [5:0], minutes in [13:8] and hours in [20:16]. All other written bits are dropped and read as zero.
- R4: The date word holds the day of month in [4:0], the month (1 to 12) in [11:8], the year offset from 2010 in [21:16] and the leap flag in bit 22. All other written bits are dropped and read as zero.
- R5: A write to the time word sets status bit 8, and a write to the date word sets status bit 7. Each bit stays set for exactly COMMIT_CYCLES cycles, and the staged value is loaded at the edge that clears it. Reads made before that load return the old, still-advancing value.
- R6: A time or date write made while that word's busy bit is set is ignored. Writes to the status word or to unused addresses change nothing.
- R7: On a tick, seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and carry into the day. Without a tick, time and date hold.
- R8: A tick in the same cycle as a commit of either word is discarded.
- R9: February rolls over to March 1 after day 28 when the leap flag is 0, and after day 29 when it is 1.
- R10: April, June, September and November roll over after day 30. Every other month rolls over after day 31.
- R11: A rollover past December 31 gives January 1 of the next year offset and clears the leap flag. Year offset 63 wraps to 0.
- R12: A loaded time or date field at or above its last legal value wraps on the next carry into it, as if it held the last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
Every cycle, the embedded assertions check these properties:
- A busy flag holds until its commit pulse and clears right after it.
- Staged values stay put while busy.
- Single-step second and day increments are correct.
- Counters hold without a tick.
- The leap flag is never set just after the year changes on its own.
- The status read never carries stray bits.
- A tick coinciding with a date commit leaves the time untouched.

Only the bench scenarios can show the exact COMMIT_CYCLES timing seen over the bus and the old value still advancing during the busy window. They also cover the month-length rollovers for February with and without the leap flag, 30- and 31-day months, the December and year-63 wraps, and the field masking and out-of-range wrap seen through register reads.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } hms_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] yr;
    logic [3:0] mo;
    logic [4:0] dy;
  } ymd_t;

  localparam logic [5:0] SEC_LAST   = 6'd59;
  localparam logic [5:0] MIN_LAST   = 6'd59;
  localparam logic [4:0] HOUR_LAST  = 5'd23;
  localparam logic [3:0] MONTH_LAST = 4'd12;

  localparam int TBUSY_BIT = 8;
  localparam int DBUSY_BIT = 7;

  function automatic logic [4:0] month_days(input logic [3:0] mo, input logic leap);
    logic [4:0] n;
    case (mo)
      4'd2:                      n = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
      default:                   n = 5'd31;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cal_wr_sync.sv
module cal_wr_sync #(
  parameter int W     = 16,
  parameter int DELAY = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic         commit,
  output logic [W-1:0] held
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      held <= '0;
    end else if (wr_en && cnt == '0) begin
      held <= wr_data;
      cnt  <= CW'(DELAY);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy   = (cnt != '0);
  assign commit = (cnt == CW'(1));

  p_busy_start_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en) |=> busy);
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !commit) |=> busy);
  p_commit_clear_r5: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy);
  p_staged_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> $stable(held));

endmodule

// File: rtl/cal_hms.sv
module cal_hms
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic load,
  input  hms_t load_val,
  output hms_t cur,
  output logic day_carry
);
  logic sc_end, mn_end, hr_end;

  assign sc_end = (cur.sc >= SEC_LAST);
  assign mn_end = (cur.mn >= MIN_LAST);
  assign hr_end = (cur.hr >= HOUR_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (load) begin
      cur <= load_val;
    end else if (tick) begin
      if (sc_end) begin
        cur.sc <= '0;
        if (mn_end) begin
          cur.mn <= '0;
          if (hr_end) cur.hr <= '0;
          else        cur.hr <= cur.hr + 1'b1;
        end else begin
          cur.mn <= cur.mn + 1'b1;
        end
      end else begin
        cur.sc <= cur.sc + 1'b1;
      end
    end
  end

  assign day_carry = tick & ~load & sc_end & mn_end & hr_end;

  p_sec_step_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cur.sc < 6'd59) |=> (cur.sc == $past(cur.sc) + 6'd1));
  p_time_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cur));

endmodule

// File: rtl/cal_ymd.sv
module cal_ymd
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic load,
  input  ymd_t load_val,
  output ymd_t cur
);
  logic [4:0] dim;
  logic       day_end, mo_end;

  assign dim     = month_days(cur.mo, cur.leap);
  assign day_end = (cur.dy >= dim);
  assign mo_end  = (cur.mo >= MONTH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur.leap <= 1'b0;
      cur.yr   <= '0;
      cur.mo   <= 4'd1;
      cur.dy   <= 5'd1;
    end else if (load) begin
      cur <= load_val;
    end else if (inc) begin
      if (day_end) begin
        cur.dy <= 5'd1;
        if (mo_end) begin
          cur.mo   <= 4'd1;
          cur.yr   <= cur.yr + 1'b1;
          cur.leap <= 1'b0;
        end else begin
          cur.mo <= cur.mo + 1'b1;
        end
      end else begin
        cur.dy <= cur.dy + 1'b1;
      end
    end
  end

  p_day_step_r9: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && cur.dy < 5'd28) |=> (cur.dy == $past(cur.dy) + 5'd1));
  p_date_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(cur));
  p_leap_clear_r11: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((cur.yr == $past(cur.yr)) || !cur.leap));

endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
  import cal_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter int COMMIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(8);
  localparam int HW = $bits(hms_t);
  localparam int DW = $bits(ymd_t);

  logic wr_time, wr_date;
  hms_t time_in, time_held, now_t;
  ymd_t date_in, date_held, now_d;
  logic t_busy, t_commit, d_busy, d_commit;
  logic tick_eff, day_carry;
  logic [31:0] rd_word;
  logic unused_wdata;

  assign wr_time = bus_sel & bus_we & (bus_addr == A_TIME);
  assign wr_date = bus_sel & bus_we & (bus_addr == A_DATE);

  always_comb begin
    time_in.hr   = bus_wdata[20:16];
    time_in.mn   = bus_wdata[13:8];
    time_in.sc   = bus_wdata[5:0];
    date_in.leap = bus_wdata[22];
    date_in.yr   = bus_wdata[21:16];
    date_in.mo   = bus_wdata[11:8];
    date_in.dy   = bus_wdata[4:0];
  end

  assign unused_wdata = ^{bus_wdata[DATA_W-1:23], bus_wdata[15:14], bus_wdata[7:6]};

  cal_wr_sync #(.W(HW), .DELAY(COMMIT_CYCLES)) u_tsync (
    .clk(clk), .rst(rst), .wr_en(wr_time), .wr_data(time_in),
    .busy(t_busy), .commit(t_commit), .held(time_held)
  );

  cal_wr_sync #(.W(DW), .DELAY(COMMIT_CYCLES)) u_dsync (
    .clk(clk), .rst(rst), .wr_en(wr_date), .wr_data(date_in),
    .busy(d_busy), .commit(d_commit), .held(date_held)
  );

  assign tick_eff = sec_tick & ~t_commit & ~d_commit;

  cal_hms u_hms (
    .clk(clk), .rst(rst), .tick(tick_eff), .load(t_commit),
    .load_val(time_held), .cur(now_t), .day_carry(day_carry)
  );

  cal_ymd u_ymd (
    .clk(clk), .rst(rst), .inc(day_carry), .load(d_commit),
    .load_val(date_held), .cur(now_d)
  );

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_word[TBUSY_BIT] = t_busy;
        rd_word[DBUSY_BIT] = d_busy;
      end
      A_DATE: rd_word = {9'd0, now_d.leap, now_d.yr, 4'd0, now_d.mo, 3'd0, now_d.dy};
      A_TIME: rd_word = {11'd0, now_t.hr, 2'd0, now_t.mn, 2'd0, now_t.sc};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= DATA_W'(rd_word);
  end

  p_ctrl_clean_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == A_CTRL) |=>
      (bus_rdata[DATA_W-1:9] == '0 && bus_rdata[6:0] == '0));
  p_tick_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && d_commit && !t_commit) |=> $stable(now_t));

endmodule

// File: tb/sim_cal_clock_core.sv
module sim_cal_clock_core;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  cal_clock_core #(.ADDR_W(4), .DATA_W(32), .COMMIT_CYCLES(D)) u0 (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // monitor: pops expected values as reads complete
  initial begin
    forever begin
      @(posedge clk);
      if (bus_sel && !bus_we) begin
        @(negedge clk);
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL scoreboard empty: actual %08h expected none", bus_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  task automatic drive(input logic s, input logic w, input logic [3:0] a,
                       input logic [31:0] d, input logic tk);
    @(negedge clk);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; sec_tick = tk;
  endtask

  task automatic idle(input int n, input logic tk);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 4'h0, 32'h0, tk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    drive(1'b1, 1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    drive(1'b1, 1'b0, a, 32'h0, 1'b0);
  endtask

  task automatic set_time(input logic [31:0] v);
    wr(4'h8, v);
    idle(D, 1'b0);
  endtask

  task automatic set_date(input logic [31:0] v);
    wr(4'h4, v);
    idle(D, 1'b0);
  endtask

  task automatic roll(input logic [31:0] din, input logic [31:0] dexp, input string t);
    set_date(din);
    set_time(32'h00173B3B);
    idle(1, 1'b1);
    rd(4'h8, 32'h0, t);
    rd(4'h4, dexp, t);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R2 map
    rd(4'h0, 32'h0, "R1 ctrl");
    rd(4'h8, 32'h0, "R1 time");
    rd(4'h4, 32'h00000101, "R1 date");
    rd(4'hC, 32'h0, "R2 unused addr");

    // R5 busy timing: write at E0
    wr(4'h8, 32'h00173B3A);
    rd(4'h0, 32'h00000100, "R5 busy set");   // E1
    rd(4'h8, 32'h0, "R5 old value");         // E2
    rd(4'h0, 32'h00000100, "R5 busy E3");    // E3
    rd(4'h0, 32'h00000100, "R5 busy last");  // E4 commit edge
    rd(4'h0, 32'h0, "R5 busy clear");        // E5
    rd(4'h8, 32'h00173B3A, "R5 new time R3"); // E6

    // R5 separate date busy bit
    wr(4'h8, 32'h0);                         // E0
    wr(4'h4, 32'h0005021C);                  // E1
    rd(4'h0, 32'h00000180, "R5 both busy");  // E2
    idle(1, 1'b0);                           // E3
    rd(4'h0, 32'h00000180, "R5 both busy2"); // E4
    rd(4'h0, 32'h00000080, "R5 date busy");  // E5
    rd(4'h0, 32'h0, "R5 all clear");         // E6
    rd(4'h4, 32'h0005021C, "R4 date word");

    // R8 tick at commit dropped, tick during busy advances old value
    wr(4'h8, 32'h000A0B0C);                  // E0
    idle(1, 1'b1);                           // E1 tick: 0 -> 1
    rd(4'h8, 32'h00000001, "R5 old advancing"); // E2
    idle(1, 1'b0);                           // E3
    idle(1, 1'b1);                           // E4 commit + tick
    rd(4'h8, 32'h000A0B0C, "R8 time commit tick"); // E5
    wr(4'h4, 32'h00060305);                  // E0
    idle(D - 1, 1'b0);
    idle(1, 1'b1);                           // date commit + tick
    rd(4'h8, 32'h000A0B0C, "R8 date commit tick");
    rd(4'h4, 32'h00060305, "R8 date loaded");

    // R6 ignored writes
    wr(4'h8, 32'h00000001);
    wr(4'h8, 32'h00000002);
    idle(D - 1, 1'b0);
    rd(4'h8, 32'h00000001, "R6 write while busy");
    wr(4'h0, 32'hFFFFFFFF);
    rd(4'h0, 32'h0, "R6 ctrl write");
    wr(4'hC, 32'hFFFFFFFF);
    idle(D, 1'b0);
    rd(4'h8, 32'h00000001, "R6 unused addr write time");
    rd(4'h4, 32'h00060305, "R6 unused addr write date");

    // R7 carries and hold
    set_time(32'h0000003B);
    idle(1, 1'b1);
    rd(4'h8, 32'h00000100, "R7 sec carry");
    set_time(32'h00003B3B);
    idle(1, 1'b1);
    rd(4'h8, 32'h00010000, "R7 min carry");
    idle(3, 1'b0);
    rd(4'h8, 32'h00010000, "R7 hold no tick");

    // R3 masking and R12 wrap from out-of-range
    set_date(32'h0006011E);
    set_time(32'hFFFFFFFF);
    rd(4'h8, 32'h001F3F3F, "R3 mask time");
    idle(1, 1'b1);
    rd(4'h8, 32'h0, "R12 wrap all");
    rd(4'h4, 32'h0006011F, "R10 Jan 31 no roll");

    // calendar rollovers
    roll(32'h0005021C, 32'h00050301, "R9 Feb 28 no leap");
    roll(32'h0045021C, 32'h0045021D, "R9 Feb 29 leap");
    roll(32'h0045021D, 32'h00450301, "R9 Feb 29 end");
    roll(32'h0005041E, 32'h00050501, "R10 Apr 30");
    roll(32'h00050B1E, 32'h00050C01, "R10 Nov 30");
    roll(32'h00450C1F, 32'h00060101, "R11 Dec 31");
    roll(32'h003F0C1F, 32'h00000101, "R11 year wrap");

    // R4 masking of date word
    set_date(32'hFFFFFFFF);
    rd(4'h4, 32'h007F0F1F, "R4 mask date");

    idle(4, 1'b0);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", exp_q.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule